// File: doc/BRIEF.md
# Fractional-Rate Master Time Counter

This block keeps a 64-bit time count that advances at a fixed real-time rate, whatever the frequency of the clock it runs on. Software sets a 12-bit step numerator and a 12-bit modulus denominator in two registers on a simple 32-bit read/write port. On each clock, a fractional accumulator adds the numerator. When the sum reaches the denominator, the accumulator wraps and the count moves forward by one. The average count rate is therefore the clock frequency times numerator over denominator.

After reset the ratio is 4/25. That gives 6.144 MHz from a 38.4 MHz clock. Other clocks are handled by loading a matching ratio:

| Ratio | Clock |
|-------|-------|
| 64/125 | 12 MHz |
| 8/25 | 19.2 MHz |
| 192/625 | 20 MHz |
| 384/1625 | 26 MHz |
| 768/1625 | 13 MHz |
| 256/1125 | 27 MHz |
| 75/244 | Fallback case on a 20 MHz-class clock |

The count is driven on an output bus and is also readable as two words. Each advance is marked by a one-cycle tick strobe. A write to either ratio register restarts the fraction from zero. It never moves the count backwards.

Top module: `frac_time_counter`

## Requirements
- R1: Synchronous active-high reset sets the count to 0, the tick low, the accumulator to 0, the register at 0x10 to 4 and the register at 0x14 to 25 (upper bits zero).
- R2: On each clock that is not a ratio write, with denominator D nonzero and numerator N < D, the accumulator gains N. When the sum is at least D, D is removed, the count rises by exactly one and the tick is high for that one cycle. Otherwise the count holds and the tick is low.
- R3: Starting from a cleared accumulator, exactly k·N increments occur over k·D clocks, for every supported ratio.
- R4: When N ≥ D and D ≠ 0, the count rises by one on every clock and the accumulator stays at 0.
- R5: When D = 0, the count holds and the tick stays low.
- R6: A write to 0x10 or 0x14 clears the accumulator. On that clock the tick is low and the count is unchanged. The new ratio is used from the next clock.
- R7: N is bits [11:0] of the word at 0x10 and D is bits [11:0] of the word at 0x14. Bits [31:12] of both words are stored on write and read back unchanged, and have no effect on counting.
- R8: A read returns data on busRdData one clock after busRdEn. A read of 0x00 returns the low 32 count bits and captures the high 32 bits. A read of 0x04 returns the captured high word.
- R9: Writes to any offset other than 0x10 and 0x14 have no effect. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 8 | Byte offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid one clock after busRdEn |
| countValue | output | 64 | Current time count |
| tickPulse | output | 1 | High for the cycle in which the count has just advanced |

## Verification
The bench loads each supported ratio and checks that exactly k·N advances occur over k·D clocks. A wrap compare that is off by one, or a remainder that is dropped, would show up as a drift in that total. It also drives N ≥ D and D = 0. A design that carried leftover fraction would tick twice or miss clocks in the first case, and one that divided by zero would keep counting in the second. Rewrites in the middle of a run, with the accumulator part-full, catch a design that keeps the stale fraction or resets the count. Writes that set the upper register bits catch a design that lets those bits reach the ratio. A cycle-accurate model is compared with the count and the tick on every clock.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  // Strobes from the register side to the accumulator datapath.
  typedef struct packed {
    logic clearAcc;  // ratio register written this cycle
    logic saturate;  // numerator not below a nonzero denominator
    logic freeze;    // denominator is zero
  } ftcStrobe_t;

  localparam int unsigned RATIO_COUNT = 2;

endpackage

// File: rtl/ftc_regs.sv
module ftc_regs
  import ftc_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned RATIO_W = 12,
  parameter int unsigned COUNT_W = 64,
  parameter logic [ADDR_W-1:0] LO_OFS  = 8'h00,
  parameter logic [ADDR_W-1:0] HI_OFS  = 8'h04,
  parameter logic [ADDR_W-1:0] NUM_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_OFS = 8'h14,
  parameter int unsigned DEF_NUM = 4,
  parameter int unsigned DEF_DEN = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic [COUNT_W-1:0] countValue,
  output logic [DATA_W-1:0]  busRdData,
  output logic [RATIO_W-1:0] numValue,
  output logic [RATIO_W-1:0] denValue,
  output ftcStrobe_t         ctrlStrobe
);

  localparam int unsigned HI_W = COUNT_W - DATA_W;

  logic [DATA_W-1:0]      ratioWord [RATIO_COUNT];
  logic [RATIO_COUNT-1:0] ratioHit;
  logic [HI_W-1:0]        hiLatchQ;
  logic [DATA_W-1:0]      rdDataQ;

  // One storage word per ratio register; index 0 is the numerator.
  for (genvar g = 0; g < RATIO_COUNT; g++) begin : gRatio
    localparam logic [ADDR_W-1:0] OFS     = (g == 0) ? NUM_OFS : DEN_OFS;
    localparam logic [DATA_W-1:0] RST_VAL = (g == 0) ? DATA_W'(DEF_NUM) : DATA_W'(DEF_DEN);
    logic [DATA_W-1:0] wordQ;

    assign ratioHit[g] = busWrEn && (busAddr == OFS);

    always_ff @(posedge clk) begin
      if (rst) begin
        wordQ <= RST_VAL;
      end else if (ratioHit[g]) begin
        wordQ <= busWrData;
      end
    end

    assign ratioWord[g] = wordQ;
  end

  assign numValue = ratioWord[0][RATIO_W-1:0];
  assign denValue = ratioWord[1][RATIO_W-1:0];

  always_comb begin
    ctrlStrobe.clearAcc = |ratioHit;
    ctrlStrobe.freeze   = (denValue == '0);
    ctrlStrobe.saturate = (denValue != '0) && (numValue >= denValue);
  end

  // Registered read port; a low-word read captures the high word.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdDataQ  <= '0;
      hiLatchQ <= '0;
    end else if (busRdEn) begin
      if (busAddr == LO_OFS) begin
        rdDataQ  <= countValue[DATA_W-1:0];
        hiLatchQ <= countValue[COUNT_W-1:DATA_W];
      end else if (busAddr == HI_OFS) begin
        rdDataQ <= DATA_W'(hiLatchQ);
      end else if (busAddr == NUM_OFS) begin
        rdDataQ <= ratioWord[0];
      end else if (busAddr == DEN_OFS) begin
        rdDataQ <= ratioWord[1];
      end else begin
        rdDataQ <= '0;
      end
    end
  end

  assign busRdData = rdDataQ;

endmodule

// File: rtl/ftc_accum.sv
module ftc_accum
  import ftc_pkg::*;
#(
  parameter int unsigned RATIO_W = 12,
  parameter int unsigned COUNT_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  ftcStrobe_t         ctrlStrobe,
  input  logic [RATIO_W-1:0] numValue,
  input  logic [RATIO_W-1:0] denValue,
  output logic [RATIO_W:0]   accValue,
  output logic [COUNT_W-1:0] countValue,
  output logic               tickPulse
);

  localparam int unsigned ACC_W = RATIO_W + 1;

  logic [ACC_W-1:0]   accQ;
  logic [ACC_W-1:0]   accNext;
  logic [ACC_W-1:0]   sumVal;
  logic               stepNow;
  logic [COUNT_W-1:0] countQ;
  logic               tickQ;

  assign sumVal = accQ + {1'b0, numValue};

  always_comb begin
    accNext = accQ;
    stepNow = 1'b0;
    if (ctrlStrobe.clearAcc) begin
      accNext = '0;
    end else if (ctrlStrobe.freeze) begin
      accNext = accQ;
    end else if (ctrlStrobe.saturate) begin
      accNext = '0;
      stepNow = 1'b1;
    end else if (sumVal >= {1'b0, denValue}) begin
      accNext = sumVal - {1'b0, denValue};
      stepNow = 1'b1;
    end else begin
      accNext = sumVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ   <= '0;
      countQ <= '0;
      tickQ  <= 1'b0;
    end else begin
      accQ  <= accNext;
      tickQ <= stepNow;
      if (stepNow) begin
        countQ <= countQ + COUNT_W'(1);
      end
    end
  end

  assign accValue   = accQ;
  assign countValue = countQ;
  assign tickPulse  = tickQ;

endmodule

// File: rtl/frac_time_counter.sv
module frac_time_counter
  import ftc_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned RATIO_W = 12,
  parameter int unsigned COUNT_W = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] NUM_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_OFS = 8'h14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic [COUNT_W-1:0] countValue,
  output logic               tickPulse
);

  logic [RATIO_W-1:0] numValue;
  logic [RATIO_W-1:0] denValue;
  logic [RATIO_W:0]   accValue;
  ftcStrobe_t         ctrlStrobe;

  ftc_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .RATIO_W(RATIO_W),
    .COUNT_W(COUNT_W),
    .NUM_OFS(NUM_OFS),
    .DEN_OFS(DEN_OFS)
  ) i_regs (
    .clk       (clk),
    .rst       (rst),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .countValue(countValue),
    .busRdData (busRdData),
    .numValue  (numValue),
    .denValue  (denValue),
    .ctrlStrobe(ctrlStrobe)
  );

  ftc_accum #(
    .RATIO_W(RATIO_W),
    .COUNT_W(COUNT_W)
  ) i_accum (
    .clk       (clk),
    .rst       (rst),
    .ctrlStrobe(ctrlStrobe),
    .numValue  (numValue),
    .denValue  (denValue),
    .accValue  (accValue),
    .countValue(countValue),
    .tickPulse (tickPulse)
  );

endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned RATIO_W = 12,
  parameter int unsigned COUNT_W = 64,
  parameter logic [ADDR_W-1:0] NUM_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_OFS = 8'h14
) (
  input logic               clk,
  input logic               rst,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [RATIO_W-1:0] numValue,
  input logic [RATIO_W-1:0] denValue,
  input logic [RATIO_W:0]   accValue,
  input logic [COUNT_W-1:0] countValue,
  input logic               tickPulse
);

  logic pastValid;
  logic ratioWrite;

  always_ff @(posedge clk) pastValid <= !rst;

  assign ratioWrite = busWrEn && (busAddr == NUM_OFS || busAddr == DEN_OFS);

  AST_TICK_ADVANCES_ONE: assert property (@(posedge clk) disable iff (rst)
    (pastValid && tickPulse) |-> countValue == $past(countValue) + COUNT_W'(1)); // R2

  AST_QUIET_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !tickPulse) |-> countValue == $past(countValue)); // R2

  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    (pastValid && denValue != '0 && numValue < denValue) |-> accValue < {1'b0, denValue}); // R2

  AST_SATURATE_EVERY_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !ratioWrite && denValue != '0 && numValue >= denValue) |=> tickPulse); // R4

  AST_ZERO_DEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (pastValid && !ratioWrite && denValue == '0) |=> (!tickPulse && $stable(countValue))); // R5

  AST_WRITE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (pastValid && ratioWrite) |=> (!tickPulse && $stable(countValue))); // R6

endmodule

bind frac_time_counter ftc_checker #(
  .ADDR_W (ADDR_W),
  .RATIO_W(RATIO_W),
  .COUNT_W(COUNT_W),
  .NUM_OFS(NUM_OFS),
  .DEN_OFS(DEN_OFS)
) i_ftc_checker (
  .clk       (clk),
  .rst       (rst),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .numValue  (numValue),
  .denValue  (denValue),
  .accValue  (accValue),
  .countValue(countValue),
  .tickPulse (tickPulse)
);

// File: tb/test_frac_time_counter.sv
`timescale 1ns/1ps
module test_frac_time_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] countValue;
  logic        tickPulse;

  int errors = 0;
  int checks = 0;
  bit modelOn = 1'b0;

  // behavioural reference state
  logic [31:0]     mNumWord, mDenWord;
  int              mAcc;
  longint unsigned mCnt;
  bit              mTick;

  always #2 clk = ~clk;

  frac_time_counter i_frac_time_counter (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .countValue(countValue), .tickPulse(tickPulse)
  );

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model, stepped on each rising edge.
  always @(posedge clk) begin
    int n, d;
    if (rst) begin
      mNumWord = 32'd4; mDenWord = 32'd25; mAcc = 0; mCnt = 0; mTick = 0;
    end else begin
      mTick = 0;
      n = int'(mNumWord[11:0]);
      d = int'(mDenWord[11:0]);
      if (busWrEn && (busAddr == 8'h10 || busAddr == 8'h14)) begin
        if (busAddr == 8'h10) mNumWord = busWrData; else mDenWord = busWrData;
        mAcc = 0;
      end else if (d != 0) begin
        if (n >= d) begin
          mAcc = 0; mCnt++; mTick = 1;
        end else begin
          mAcc += n;
          if (mAcc >= d) begin mAcc -= d; mCnt++; mTick = 1; end
        end
      end
    end
  end

  // Per-clock comparison against the model (R2, R4, R5, R6, R9).
  always @(negedge clk) begin
    if (modelOn) begin
      check("R2 count vs model", countValue, mCnt);
      check("R2 tick vs model", longint'(tickPulse), longint'(mTick));
    end
  end

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d, output logic [63:0] snap);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a; snap = countValue;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic runRatio(int n, int d, int k, string tag);
    longint unsigned c0;
    busWrite(8'h10, 32'(n));
    busWrite(8'h14, 32'(d));
    c0 = countValue;
    repeat (k * d) @(negedge clk);
    check(tag, countValue - c0, longint'(k * n));
  endtask

  initial begin
    logic [31:0] rd;
    logic [63:0] snap;
    longint unsigned c0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    modelOn = 1'b1;
    // R1 reset state
    check("R1 count after reset", countValue, 0);
    check("R1 tick after reset", longint'(tickPulse), 0);
    busRead(8'h10, rd, snap);
    check("R1 numerator default", rd, 4);
    busRead(8'h14, rd, snap);
    check("R1 denominator default", rd, 25);

    // R3 exact totals for each supported ratio
    runRatio(4, 25, 4, "R3 ratio 4/25");
    runRatio(64, 125, 2, "R3 ratio 64/125");
    runRatio(8, 25, 3, "R3 ratio 8/25");
    runRatio(192, 625, 2, "R3 ratio 192/625");
    runRatio(384, 1625, 1, "R3 ratio 384/1625");
    runRatio(768, 1625, 1, "R3 ratio 768/1625");
    runRatio(256, 1125, 1, "R3 ratio 256/1125");
    runRatio(75, 244, 2, "R3 ratio 75/244");

    // R4 saturation
    runRatio(30, 20, 0, "R4 setup");
    c0 = countValue;
    repeat (10) @(negedge clk);
    check("R4 one step per clock", countValue - c0, 10);

    // R5 zero denominator
    busWrite(8'h14, 32'd0);
    c0 = countValue;
    repeat (50) @(negedge clk);
    check("R5 frozen count", countValue - c0, 0);

    // R6 rewrite with a partly filled accumulator
    busWrite(8'h10, 32'd7);
    busWrite(8'h14, 32'd9);
    repeat (5) @(negedge clk);
    c0 = countValue;
    busWrite(8'h10, 32'd7);
    check("R6 count kept on write", countValue - c0 <= 1, 1);
    c0 = countValue;
    repeat (9) @(negedge clk);
    check("R6 fresh fraction after write", countValue - c0, 7);

    // R7 upper bits stored, no effect on counting
    busWrite(8'h10, 32'hABCDE040);
    busWrite(8'h14, 32'h5A5A507D);
    busRead(8'h10, rd, snap);
    check("R7 numerator readback", rd, 32'hABCDE040);
    busRead(8'h14, rd, snap);
    check("R7 denominator readback", rd, 32'h5A5A507D);
    busWrite(8'h14, 32'hFFFFF07D);
    c0 = countValue;
    repeat (250) @(negedge clk);
    check("R7 upper bits ignored 64/125", countValue - c0, 128);

    // R8 split read
    busRead(8'h00, rd, snap);
    check("R8 low word", rd, snap[31:0]);
    busRead(8'h04, rd, snap);
    check("R8 latched high word", rd, 0);

    // R9 writes elsewhere ignored, unmapped read zero
    busWrite(8'h00, 32'hFFFFFFFF);
    busWrite(8'h04, 32'hFFFFFFFF);
    busWrite(8'h20, 32'hFFFFFFFF);
    busRead(8'h10, rd, snap);
    check("R9 numerator untouched", rd, 32'hABCDE040);
    busRead(8'h20, rd, snap);
    check("R9 unmapped read", rd, 0);
    busRead(8'h00, rd, snap);
    check("R9 count untouched", rd, snap[31:0]);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule